// File: doc/BRIEF.md
# Clock-Synthesizer Register Port over a Two-Wire Serial Bus

This block is the control front end of a programmable clock source. It sits on an I2C-compatible two-wire bus as a slave with a fixed 7-bit device address, which is set as a parameter. It holds the settings the synthesis core needs: a high-speed divider code, an output divider code and a 38-bit fractional multiplier word. It also holds a control register with three command bits that clear themselves, and a hold register whose single freeze bit stops the core while a new setting is loaded. Decoded fields and command strobes go straight to the core as plain signals.

A host writes by sending the device address with the direction bit low, then one register pointer byte, then any number of data bytes. A host reads by writing the pointer, issuing a repeated START and the address with the direction bit high, then clocking out bytes. The pointer advances by one after every data byte in either direction. SCL and SDA are sampled by the system clock through synchronisers. SDA is open drain: the block only ever pulls it low. The block never stretches the clock, so there is no back-pressure on the bus side; the host paces every bit.

A recall command reloads the divider and multiplier registers from parameter defaults. A reset command holds the core in reset for a parameterised number of cycles, switches the clock output off during that time, and then restores all settings to their defaults.

Top module: `clkgen_i2c_regport`

## Requirements
- R1: The block acknowledges a START followed by its own 7-bit address. A byte whose upper seven bits name another address gets no ACK, and SDA stays released for the rest of that transaction, until the next START or STOP.
- R2: In a write, the first byte after the address is the register pointer. Each following byte is acknowledged and stored at the pointer, and the new value is visible on the field outputs once the STOP is sent.
- R3: The pointer advances by one after every data byte written or read, so several consecutive registers can be reached in one transaction.
- R4: A read (pointer write, repeated START, address with R/W=1) returns the register at the pointer, most significant bit first.
- R5: When the host answers a read byte with NACK, the block releases SDA and drives nothing more until the next START, however many further clocks follow.
- R6: Field layout, which the core decodes. Register 7 = {hs[2:0], n1[6:2]}. Register 8 = {n1[1:0], mult[37:32]}. Registers 9, 10, 11 and 12 hold mult[31:24], mult[23:16], mult[15:8] and mult[7:0].
- R7: Register 135 reads {reset_active, newfreq, 5'b0, recall}, and bits 5:1 always read zero. Writing bit 6 as 1 gives exactly one cycle of newfreq_o. The bit then clears itself and reads back 0. A write with only bits 5:1 set causes no strobe.
- R8: Writing 1 to bit 0 of register 135 gives exactly one cycle of recall_o. At the end of that cycle, registers 7 to 12 take the default values. The freeze bit is not changed, and bit 0 reads back 0.
- R9: Writing 1 to bit 7 of register 135 holds core_rst_o high for exactly RST_CYCLES cycles, with clk_out_en low for the same cycles. Bit 7 reads 1 while this lasts. When it ends, the fields return to their defaults, freeze clears and bit 7 reads 0.
- R10: Bit 4 of register 137 drives freeze_o. The other bits of register 137 read zero, and writes to them have no effect.
- R11: Writes to any address other than 7 to 12, 135 and 137 are acknowledged but change nothing. Reads from such addresses return 0.
- R12: While SCL has been high for several system cycles, the SDA drive does not change, so the block's own data never makes a false START or STOP.
- R13: After hardware reset the fields hold their default values, freeze_o and all strobes are 0, clk_out_en is 1 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_o | output | 1 | Data value driven when enabled (always 0, open drain) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| div_hs_code | output | 3 | High-speed divider code |
| div_out_code | output | 7 | Output divider code |
| mult_word | output | 38 | Fractional multiplier word |
| freeze_o | output | 1 | Core freeze level |
| newfreq_o | output | 1 | One-cycle new-setting strobe |
| recall_o | output | 1 | One-cycle recall strobe |
| core_rst_o | output | 1 | Core reset, high for RST_CYCLES cycles |
| clk_out_en | output | 1 | Clock output enable, low during core reset |

## Verification
The hardest state to reach from the pins is register 135 read back as 0x80 while the internal reset is still running. That read needs a pointer write, a repeated START and an address byte to complete inside the reset window. The bench therefore sets RST_CYCLES to several thousand and starts the read straight after the STOP of the reset write. It then waits out the window and checks the exact strobe length and the restored defaults. A second case that is hard to reach is the release after a host NACK: the bench keeps toggling SCL after the NACK and confirms that the line stays high.

// File: rtl/clkgen_regport_pkg.sv
package clkgen_regport_pkg;
  localparam int HS_W         = 3;
  localparam int N1_W         = 7;
  localparam int MULT_W       = 38;
  localparam int MULT_LO_BYTES = 4;
  localparam int PTR_W        = 8;

  localparam logic [PTR_W-1:0] A_DIV   = 8'd7;
  localparam logic [PTR_W-1:0] A_MIX   = 8'd8;
  localparam logic [PTR_W-1:0] A_MULT0 = 8'd9;
  localparam logic [PTR_W-1:0] A_CTRL  = 8'd135;
  localparam logic [PTR_W-1:0] A_HOLD  = 8'd137;

  localparam int CTRL_RST    = 7;
  localparam int CTRL_NEWF   = 6;
  localparam int CTRL_RECALL = 0;
  localparam int HOLD_FRZ    = 4;

  typedef enum logic [2:0] {EV_IDLE, EV_RX, EV_ACK, EV_TX, EV_MACK} eng_state_t;
  typedef enum logic [1:0] {RX_ADDR, RX_PTR, RX_DATA} rx_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] scl_pipe;
  logic [LAST:0] sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
      sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_pipe[LAST-1];
  assign scl_old = scl_pipe[LAST];
  assign sda_now = sda_pipe[LAST-1];
  assign sda_old = sda_pipe[LAST];

  assign sda_lvl  = sda_now;
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start_ev = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_ev  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import clkgen_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             sda_drive
);
  eng_state_t st;
  rx_kind_t   kind;
  logic [2:0] bitcnt;
  logic       byte_full;
  logic       is_read;
  logic       m_ack;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= EV_IDLE;
      kind      <= RX_ADDR;
      bitcnt    <= '0;
      byte_full <= 1'b0;
      is_read   <= 1'b0;
      m_ack     <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      sda_drive <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        st        <= EV_RX;
        kind      <= RX_ADDR;
        bitcnt    <= '0;
        byte_full <= 1'b0;
        sda_drive <= 1'b0;
      end else if (stop_ev) begin
        st        <= EV_IDLE;
        sda_drive <= 1'b0;
      end else begin
        case (st)
          EV_RX: begin
            if (scl_rise) begin
              rx_sh  <= {rx_sh[6:0], sda_lvl};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              bitcnt    <= '0;
              case (kind)
                RX_ADDR: begin
                  if (rx_sh[7:1] == DEV_ADDR) begin
                    is_read   <= rx_sh[0];
                    st        <= EV_ACK;
                    sda_drive <= 1'b1;
                  end else begin
                    st <= EV_IDLE;
                  end
                end
                RX_PTR: begin
                  ptr       <= rx_sh;
                  st        <= EV_ACK;
                  sda_drive <= 1'b1;
                end
                default: begin
                  wr_en     <= 1'b1;
                  wr_addr   <= ptr;
                  wr_data   <= rx_sh;
                  ptr       <= ptr + 8'd1;
                  st        <= EV_ACK;
                  sda_drive <= 1'b1;
                end
              endcase
            end
          end
          EV_ACK: begin
            if (scl_fall) begin
              if (kind == RX_ADDR && is_read) begin
                tx_sh     <= rd_data;
                sda_drive <= ~rd_data[7];
                ptr       <= ptr + 8'd1;
                bitcnt    <= '0;
                st        <= EV_TX;
              end else begin
                sda_drive <= 1'b0;
                kind      <= (kind == RX_ADDR) ? RX_PTR : RX_DATA;
                st        <= EV_RX;
              end
            end
          end
          EV_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_drive <= 1'b0;
                st        <= EV_MACK;
              end else begin
                tx_sh     <= {tx_sh[6:0], 1'b0};
                sda_drive <= ~tx_sh[6];
                bitcnt    <= bitcnt + 3'd1;
              end
            end
          end
          EV_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx_sh     <= rd_data;
                sda_drive <= ~rd_data[7];
                ptr       <= ptr + 8'd1;
                bitcnt    <= '0;
                st        <= EV_TX;
              end else begin
                st <= EV_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkgen_reg_bank.sv
module clkgen_reg_bank
  import clkgen_regport_pkg::*;
#(
  parameter int               RST_CYCLES = 16,
  parameter logic [HS_W-1:0]  DEF_HS     = 3'd2,
  parameter logic [N1_W-1:0]  DEF_N1     = 7'd3,
  parameter logic [MULT_W-1:0] DEF_MULT  = 38'h02D1E127AD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [7:0]        rd_data,
  output logic [HS_W-1:0]   hs_code,
  output logic [N1_W-1:0]   n1_code,
  output logic [MULT_W-1:0] mult,
  output logic              freeze,
  output logic              newf,
  output logic              recall,
  output logic              rst_active
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam int MULT_HI_W = MULT_W - 8 * MULT_LO_BYTES;

  logic [CW-1:0] rst_cnt;
  assign rst_active = (rst_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_code <= DEF_HS;
      n1_code <= DEF_N1;
      mult    <= DEF_MULT;
      freeze  <= 1'b0;
      newf    <= 1'b0;
      recall  <= 1'b0;
      rst_cnt <= '0;
    end else begin
      newf <= 1'b0;
      if (rst_active) begin
        rst_cnt <= rst_cnt - 1'b1;
        if (rst_cnt == CW'(1)) begin
          hs_code <= DEF_HS;
          n1_code <= DEF_N1;
          mult    <= DEF_MULT;
          freeze  <= 1'b0;
        end
      end
      if (recall) begin
        hs_code <= DEF_HS;
        n1_code <= DEF_N1;
        mult    <= DEF_MULT;
        recall  <= 1'b0;
      end
      if (wr_en) begin
        if (wr_addr == A_DIV) begin
          hs_code        <= wr_data[7:5];
          n1_code[6:2]   <= wr_data[4:0];
        end
        if (wr_addr == A_MIX) begin
          n1_code[1:0]   <= wr_data[7:6];
          mult[MULT_W-1 -: MULT_HI_W] <= wr_data[MULT_HI_W-1:0];
        end
        for (int i = 0; i < MULT_LO_BYTES; i++) begin
          if (wr_addr == A_MULT0 + PTR_W'(i))
            mult[8*(MULT_LO_BYTES-1-i) +: 8] <= wr_data;
        end
        if (wr_addr == A_CTRL) begin
          if (wr_data[CTRL_RST]) rst_cnt <= CW'(RST_CYCLES);
          newf   <= wr_data[CTRL_NEWF];
          recall <= wr_data[CTRL_RECALL];
        end
        if (wr_addr == A_HOLD) freeze <= wr_data[HOLD_FRZ];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_DIV)  rd_data = {hs_code, n1_code[6:2]};
    if (rd_addr == A_MIX)  rd_data = {n1_code[1:0], mult[MULT_W-1 -: MULT_HI_W]};
    for (int i = 0; i < MULT_LO_BYTES; i++) begin
      if (rd_addr == A_MULT0 + PTR_W'(i))
        rd_data = mult[8*(MULT_LO_BYTES-1-i) +: 8];
    end
    if (rd_addr == A_CTRL) begin
      rd_data[CTRL_RST]    = rst_active;
      rd_data[CTRL_NEWF]   = newf;
      rd_data[CTRL_RECALL] = recall;
    end
    if (rd_addr == A_HOLD) rd_data[HOLD_FRZ] = freeze;
  end
endmodule

// File: rtl/clkgen_i2c_regport.sv
module clkgen_i2c_regport
  import clkgen_regport_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h55,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_CYCLES  = 16,
  parameter logic [HS_W-1:0]   DEF_HS      = 3'd2,
  parameter logic [N1_W-1:0]   DEF_N1      = 7'd3,
  parameter logic [MULT_W-1:0] DEF_MULT    = 38'h02D1E127AD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  output logic [HS_W-1:0]   div_hs_code,
  output logic [N1_W-1:0]   div_out_code,
  output logic [MULT_W-1:0] mult_word,
  output logic              freeze_o,
  output logic              newfreq_o,
  output logic              recall_o,
  output logic              core_rst_o,
  output logic              clk_out_en
);
  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic [PTR_W-1:0] ptr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic wr_en, drive;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_drive(drive)
  );

  clkgen_reg_bank #(
    .RST_CYCLES(RST_CYCLES), .DEF_HS(DEF_HS), .DEF_N1(DEF_N1), .DEF_MULT(DEF_MULT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
    .hs_code(div_hs_code), .n1_code(div_out_code), .mult(mult_word),
    .freeze(freeze_o), .newf(newfreq_o), .recall(recall_o),
    .rst_active(core_rst_o)
  );

  assign sda_o      = 1'b0;
  assign sda_oe     = drive;
  assign clk_out_en = ~core_rst_o;
endmodule

// File: rtl/clkgen_i2c_regport_chk.sv
module clkgen_i2c_regport_chk
  import clkgen_regport_pkg::*;
#(
  parameter int                RST_CYCLES = 16,
  parameter logic [HS_W-1:0]   DEF_HS     = 3'd2,
  parameter logic [N1_W-1:0]   DEF_N1     = 7'd3,
  parameter logic [MULT_W-1:0] DEF_MULT   = 38'h02D1E127AD
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [HS_W-1:0]   div_hs_code,
  input logic [N1_W-1:0]   div_out_code,
  input logic [MULT_W-1:0] mult_word,
  input logic              freeze_o,
  input logic              newfreq_o,
  input logic              recall_o,
  input logic              core_rst_o
);
  int run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (core_rst_o) run_len <= run_len + 1;
    else run_len <= 0;
  end

  a_r7_newfreq_single: assert property (@(posedge clk) disable iff (!rst_n)
    newfreq_o |=> !newfreq_o);

  a_r8_recall_single: assert property (@(posedge clk) disable iff (!rst_n)
    recall_o |=> !recall_o);

  a_r8_recall_loads: assert property (@(posedge clk) disable iff (!rst_n)
    recall_o |=> (div_hs_code == DEF_HS && div_out_code == DEF_N1 && mult_word == DEF_MULT));

  a_r9_reset_restores: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> (div_hs_code == DEF_HS && div_out_code == DEF_N1 &&
                           mult_word == DEF_MULT && !freeze_o));

  a_r9_reset_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> (run_len == RST_CYCLES));

  a_r12_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe));
endmodule

bind clkgen_i2c_regport clkgen_i2c_regport_chk #(
  .RST_CYCLES(RST_CYCLES), .DEF_HS(DEF_HS), .DEF_N1(DEF_N1), .DEF_MULT(DEF_MULT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .div_hs_code(div_hs_code), .div_out_code(div_out_code), .mult_word(mult_word),
  .freeze_o(freeze_o), .newfreq_o(newfreq_o), .recall_o(recall_o),
  .core_rst_o(core_rst_o)
);

// File: tb/sim_clkgen_i2c_regport.sv
module sim_clkgen_i2c_regport;
  localparam logic [6:0]  ADDR   = 7'h55;
  localparam int          RSTC   = 3000;
  localparam logic [2:0]  D_HS   = 3'd2;
  localparam logic [6:0]  D_N1   = 7'd3;
  localparam logic [37:0] D_MULT = 38'h02D1E127AD;
  localparam int          Q      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_bus;
  logic sda_o, sda_oe, freeze_o, newfreq_o, recall_o, core_rst_o, clk_out_en;
  logic [2:0] hs;
  logic [6:0] n1;
  logic [37:0] mult;

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  clkgen_i2c_regport #(
    .DEV_ADDR(ADDR), .RST_CYCLES(RSTC), .DEF_HS(D_HS), .DEF_N1(D_N1), .DEF_MULT(D_MULT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_o(sda_o),
    .sda_oe(sda_oe), .div_hs_code(hs), .div_out_code(n1), .mult_word(mult),
    .freeze_o(freeze_o), .newfreq_o(newfreq_o), .recall_o(recall_o),
    .core_rst_o(core_rst_o), .clk_out_en(clk_out_en)
  );

  int n_checks = 0;
  int n_err = 0;
  int nf_cnt = 0, rcl_cnt = 0, rst_hi = 0, off_cnt = 0;

  typedef struct { string req; logic [7:0] val; } item_t;
  item_t exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] wbuf [8];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops received bytes against expected queue
  always @(negedge clk) begin
    if (got_q.size() > 0) begin
      logic [7:0] g;
      g = got_q.pop_front();
      if (exp_q.size() == 0) check("R4 unexpected byte", {56'd0, g}, 64'hx);
      else begin
        item_t e;
        e = exp_q.pop_front();
        check(e.req, {56'd0, g}, {56'd0, e.val});
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      nf_cnt  += int'(newfreq_o);
      rcl_cnt += int'(recall_o);
      rst_hi  += int'(core_rst_o);
      off_cnt += int'(!clk_out_en);
    end
  end

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitq(Q); m_scl = 1'b1; waitq(Q);
    m_sda = 1'b0; waitq(Q); m_scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq(Q); m_scl = 1'b1; waitq(Q); m_sda = 1'b1; waitq(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; waitq(Q); m_scl = 1'b1; waitq(2 * Q); m_scl = 1'b0; waitq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; waitq(Q); m_scl = 1'b1; waitq(Q);
    b = sda_bus; waitq(Q); m_scl = 1'b0; waitq(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack_n);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack_n);
  endtask

  task automatic get_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      v[i] = b;
    end
  endtask

  task automatic expect_byte(input string req, input logic [7:0] v);
    item_t it;
    it.req = req; it.val = v;
    exp_q.push_back(it);
  endtask

  task automatic wr_regs(input logic [7:0] ptr, input int n, input string req);
    logic a;
    bus_start();
    put_byte({ADDR, 1'b0}, a); check("R1 address ack", {63'd0, a}, 64'd0);
    put_byte(ptr, a);          check({req, " pointer ack"}, {63'd0, a}, 64'd0);
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], a);    check({req, " data ack"}, {63'd0, a}, 64'd0);
    end
    bus_stop();
    waitq(4);
  endtask

  task automatic rd_regs(input logic [7:0] ptr, input int n);
    logic a;
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(ptr, a);
    bus_start();
    put_byte({ADDR, 1'b1}, a); check("R4 read address ack", {63'd0, a}, 64'd0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      get_byte(v);
      got_q.push_back(v);
      put_bit(i == n - 1);
    end
    bus_stop();
    waitq(4);
  endtask

  task automatic expect_fields(input string req, input logic [2:0] h, input logic [6:0] d, input logic [37:0] m);
    expect_byte(req, {h, d[6:2]});
    expect_byte(req, {d[1:0], m[37:32]});
    expect_byte(req, m[31:24]);
    expect_byte(req, m[23:16]);
    expect_byte(req, m[15:8]);
    expect_byte(req, m[7:0]);
  endtask

  task automatic check_fields(input string req, input logic [2:0] h, input logic [6:0] d, input logic [37:0] m);
    check({req, " hs"}, {61'd0, hs}, {61'd0, h});
    check({req, " n1"}, {57'd0, n1}, {57'd0, d});
    check({req, " mult"}, {26'd0, mult}, {26'd0, m});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    logic a;
    logic [2:0] h1;
    logic [6:0] d1;
    logic [37:0] m1;
    waitq(5);
    rst_n = 1'b1;
    waitq(5);

    // R13 reset state
    check_fields("R13", D_HS, D_N1, D_MULT);
    check("R13 freeze", {63'd0, freeze_o}, 64'd0);
    check("R13 clk_out_en", {63'd0, clk_out_en}, 64'd1);
    check("R13 sda released", {63'd0, sda_oe}, 64'd0);

    // R4 R6 default readback
    expect_fields("R6 default read", D_HS, D_N1, D_MULT);
    rd_regs(8'd7, 6);

    // R1 foreign address ignored
    bus_start();
    put_byte({7'h2A, 1'b0}, a); check("R1 no ack foreign", {63'd0, a}, 64'd1);
    put_byte(8'd7, a);          check("R1 silent after nack", {63'd0, a}, 64'd1);
    put_byte(8'hFF, a);         check("R1 silent data", {63'd0, a}, 64'd1);
    bus_stop();
    check_fields("R1 unchanged", D_HS, D_N1, D_MULT);

    // R2 R3 R6 multi-byte write
    wbuf[0] = 8'hE5; wbuf[1] = 8'h8A; wbuf[2] = 8'h12;
    wbuf[3] = 8'h34; wbuf[4] = 8'h56; wbuf[5] = 8'h78;
    wr_regs(8'd7, 6, "R2");
    h1 = wbuf[0][7:5];
    d1 = {wbuf[0][4:0], wbuf[1][7:6]};
    m1 = {wbuf[1][5:0], wbuf[2], wbuf[3], wbuf[4], wbuf[5]};
    check_fields("R2 R6 fields", h1, d1, m1);

    // R3 R11 read across the end of the field block
    expect_fields("R3 readback", h1, d1, m1);
    expect_byte("R11 unlisted reads zero", 8'h00);
    rd_regs(8'd7, 7);

    // R4 read from a middle pointer
    expect_byte("R4 mid read", m1[23:16]);
    expect_byte("R4 mid read next", m1[15:8]);
    rd_regs(8'd10, 2);

    // R11 unlisted write discarded
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    wr_regs(8'd20, 2, "R11");
    check_fields("R11 fields kept", h1, d1, m1);
    expect_byte("R11 read unlisted", 8'h00);
    rd_regs(8'd20, 1);

    // R10 freeze
    wbuf[0] = 8'hFF;
    wr_regs(8'd137, 1, "R10");
    check("R10 freeze set", {63'd0, freeze_o}, 64'd1);
    expect_byte("R10 reserved read zero", 8'h10);
    rd_regs(8'd137, 1);
    wbuf[0] = 8'hEF;
    wr_regs(8'd137, 1, "R10");
    check("R10 freeze cleared by bit4", {63'd0, freeze_o}, 64'd0);

    // R7 fixed-zero bits
    wbuf[0] = 8'h3E;
    wr_regs(8'd135, 1, "R7");
    check("R7 no strobe", nf_cnt + rcl_cnt + rst_hi, 0);
    expect_byte("R7 bits 5:1 zero", 8'h00);
    rd_regs(8'd135, 1);

    // R7 new-frequency strobe
    wbuf[0] = 8'h40;
    wr_regs(8'd135, 1, "R7");
    check("R7 newfreq one cycle", nf_cnt, 1);
    check_fields("R7 fields kept", h1, d1, m1);
    expect_byte("R7 newfreq self-clear", 8'h00);
    rd_regs(8'd135, 1);

    // R8 recall, freeze kept
    wbuf[0] = 8'h10;
    wr_regs(8'd137, 1, "R8");
    wbuf[0] = 8'h01;
    wr_regs(8'd135, 1, "R8");
    check("R8 recall one cycle", rcl_cnt, 1);
    check_fields("R8 defaults", D_HS, D_N1, D_MULT);
    check("R8 freeze kept", {63'd0, freeze_o}, 64'd1);
    expect_byte("R8 recall self-clear", 8'h00);
    rd_regs(8'd135, 1);

    // R9 internal reset
    wbuf[0] = 8'h9C; wbuf[1] = 8'h41;
    wr_regs(8'd7, 2, "R9");
    wbuf[0] = 8'h80;
    wr_regs(8'd135, 1, "R9");
    check("R9 core reset active", {63'd0, core_rst_o}, 64'd1);
    check("R9 output off", {63'd0, clk_out_en}, 64'd0);
    expect_byte("R9 reads busy", 8'h80);
    rd_regs(8'd135, 1);
    waitq(RSTC + 10);
    check("R9 reset length", rst_hi, RSTC);
    check("R9 output-off length", off_cnt, RSTC);
    check_fields("R9 defaults", D_HS, D_N1, D_MULT);
    check("R9 freeze cleared", {63'd0, freeze_o}, 64'd0);
    expect_byte("R9 self-clear", 8'h00);
    rd_regs(8'd135, 1);

    // R5 release after NACK, extra clocks see a high line
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'd9, a);
    bus_start();
    put_byte({ADDR, 1'b1}, a);
    begin
      logic [7:0] v;
      int ones;
      get_byte(v);
      got_q.push_back(v);
      expect_byte("R5 byte before nack", D_MULT[31:24]);
      put_bit(1'b1);
      ones = 0;
      for (int i = 0; i < 9; i++) begin
        logic b;
        get_bit(b);
        ones += int'(b);
      end
      check("R5 released after nack", ones, 9);
    end
    bus_stop();

    waitq(20);
    check("R4 all expected bytes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule